// File: doc/BRIEF.md
# Word FIFO to Byte-Card Data Engine

This block sits between a register interface that moves 32-bit words and a memory card that produces or consumes one byte at a time. It owns a 16-word circular FIFO, a byte counter armed from a separate data-length register, and two converters. In the card-to-host direction, incoming bytes are packed into words little-endian. In the host-to-card direction, words are unpacked low byte first. At most one byte moves per clock cycle.

Software first writes the length and then writes the control word with the enable bit and a direction. It then feeds or drains the FIFO one word per strobe. Completion is reported on the data-end and block-end status bits. The FIFO fill state appears on a set of status bits, and only the bits for the active direction are shown. Once the counter is exhausted and the FIFO has been emptied, the engine drops its busy flag by itself.

Top module: `card_data_mover`

## Requirements
- R1: After a synchronous active-low reset: busy is 0, bytes_left is 0, the whole status vector is 0, fifo_err is 0, and neither card strobe is asserted.
- R2: A control write (ctl_wr) with ctl_en=1 loads the byte counter from the 16-bit length register and sets busy on the next cycle; ctl_dir=1 selects card-to-host. The register-side push only feeds the FIFO when the direction is host-to-card, and the register-side pop only drains it when the direction is card-to-host; otherwise they are ignored and raise no error.
- R3: In card-to-host transfers, transferred byte k lands in bits 8*(k mod 4)+7 : 8*(k mod 4) of FIFO word k/4, and words leave the FIFO in arrival order.
- R4: A byte is taken from the card (card_rd=1) only in a cycle where card_rdy=1, the counter is nonzero and the FIFO is not full. Each taken byte decrements the counter by one, and no more than one byte moves per cycle.
- R5: When the counter runs out part-way through a word, that partial word is still pushed, with its unfilled upper bytes zero.
- R6: In host-to-card transfers, each popped word is sent low byte first, one byte per cycle (card_wr=1). Sending stops when the counter reaches zero, and any unsent bytes of the last word are dropped.
- R7: Once the engine is enabled with a zero counter, status bit 8 (data end) and bit 10 (block end) are set on the following cycle. Both clear on the next control write with enable set.
- R8: While the counter is zero and the FIFO is empty, busy clears on the next cycle.
- R9: While busy, with word count c in the FIFO, the status shows: empty when c=0, data available when c>0, full when c=16, half-empty when c<=8 and half-full when c>=8. In card-to-host mode only bits 13 (active), 15 (half-full), 17 (full), 19 (empty) and 21 (available) may be set. Otherwise only bits 12 (active), 14 (half-empty), 16 (full), 18 (empty) and 20 (available) may be set.
- R10: While busy is 0, status bits 21 to 12 are all zero.
- R11: A push into a full FIFO or a pop from an empty FIFO leaves its contents unchanged and sets the sticky fifo_err output, which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_en | input | 1 | Enable bit of the control word |
| ctl_dir | input | 1 | Direction bit: 1 = card to host, 0 = host to card |
| len_wr | input | 1 | Length register write strobe |
| len_data | input | 16 | Transfer length in bytes |
| push_vld | input | 1 | Register-side word push |
| push_data | input | 32 | Word pushed from the register side |
| pop_req | input | 1 | Register-side word pop |
| pop_data | output | 32 | Head word of the FIFO (zero when empty) |
| card_rdy | input | 1 | Card has a byte ready |
| card_rd_data | input | 8 | Byte offered by the card |
| card_rd | output | 1 | Byte taken from the card this cycle |
| card_wr | output | 1 | Byte sent to the card this cycle |
| card_wr_data | output | 8 | Byte sent to the card |
| busy | output | 1 | Engine enabled |
| bytes_left | output | 16 | Remaining byte count |
| stat | output | 22 | Status vector (bits 8, 10, 12 to 21 used) |
| fifo_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The assertions assume that software does not write the length register and a control word in the same cycle, and that the register side issues at most one push or pop strobe per cycle, each one cycle wide. The stimulus drives every strobe for exactly one cycle between falling edges, and it always loads the length before arming a transfer. Register pushes are issued only while the host-to-card direction is selected, except in the single case that checks they are ignored. The card model changes its ready and data lines only on falling edges, so each byte the engine takes is the one offered during that whole cycle.

// File: rtl/engine_pkg.sv
// Shared constants for the card data engine: status bit positions and direction codes.
// Assumes a 22-bit status vector whose bit positions are decoded by the register block.
package engine_pkg;
    localparam int STAT_W          = 22;
    localparam int BIT_DATA_END    = 8;
    localparam int BIT_BLOCK_END   = 10;
    localparam int BIT_TX_ACTIVE   = 12;
    localparam int BIT_RX_ACTIVE   = 13;
    localparam int BIT_TX_HALF_EMP = 14;
    localparam int BIT_RX_HALF_FUL = 15;
    localparam int BIT_TX_FULL     = 16;
    localparam int BIT_RX_FULL     = 17;
    localparam int BIT_TX_EMPTY    = 18;
    localparam int BIT_RX_EMPTY    = 19;
    localparam int BIT_TX_AVAIL    = 20;
    localparam int BIT_RX_AVAIL    = 21;

    typedef enum logic {
        DIR_TO_CARD   = 1'b0,
        DIR_FROM_CARD = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/mover_word_fifo.sv
// Circular word FIFO. The write slot is the read pointer plus the fill count, modulo DEPTH.
// Pushes into a full FIFO and pops from an empty one are dropped and latch a sticky error.
// Assumes DEPTH is a power of two.
module mover_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty,
    output logic                       err
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wr_idx;
    logic             do_wr;
    logic             do_rd;

    assign full   = (count_q == CNT_W'(DEPTH));
    assign empty  = (count_q == '0);
    assign do_wr  = wr_en && !full;
    assign do_rd  = rd_en && !empty;
    assign wr_idx = rd_ptr + count_q[PTR_W-1:0];
    assign head   = empty ? '0 : mem[rd_ptr];
    assign count  = count_q;

    // Storage write: no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Pointer, fill count and sticky error update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            count_q <= '0;
            err     <= 1'b0;
        end else begin
            if (do_rd) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            count_q <= count_q + CNT_W'(do_wr) - CNT_W'(do_rd);
            err     <= err || (wr_en && full) || (rd_en && empty);
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && full) |=> (count == CNT_W'(DEPTH) && err)); // R11
    AST_EMPTY_POP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && empty) |=> (count == '0 && err)); // R11
endmodule

// File: rtl/mover_byte_packer.sv
// Assembles card bytes into words, lowest lane first. A word is emitted when its top lane
// fills or when the byte marked last arrives, so a partial final word is still emitted.
// Assumes WIDTH is a multiple of 8 and at least 16.
module mover_byte_packer #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             last,
    input  logic [7:0]       byte_in,
    output logic             push,
    output logic [WIDTH-1:0] word_out
);
    localparam int LANES  = WIDTH / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] lane;
    logic [WIDTH-1:0]  acc;
    logic [WIDTH-1:0]  merged;

    // Insert the incoming byte into its lane of the partial word.
    always_comb begin
        merged = acc;
        merged[int'(lane)*8 +: 8] = byte_in;
    end

    assign push     = take && ((lane == LANE_W'(LANES - 1)) || last);
    assign word_out = merged;

    // Lane pointer and accumulator advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lane <= '0;
            acc  <= '0;
        end else if (push) begin
            lane <= '0;
            acc  <= '0;
        end else if (take) begin
            lane <= lane + LANE_W'(1);
            acc  <= merged;
        end
    end
endmodule

// File: rtl/mover_byte_unpacker.sv
// Splits FIFO words into card bytes, low byte first. The first byte of a word is sent
// straight from the FIFO head in the cycle it is popped; the rest come from a shift register.
// Assumes WIDTH is a multiple of 8 and at least 16.
module mover_byte_unpacker #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [WIDTH-1:0] head,
    output logic [7:0]       byte_out,
    output logic             need_pop,
    output logic             holding
);
    localparam int LANES  = WIDTH / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [WIDTH-1:0]  shreg;
    logic [LANE_W-1:0] rem;

    assign holding  = (rem != '0);
    assign byte_out = holding ? shreg[7:0] : head[7:0];
    assign need_pop = take && !holding;

    // Load a fresh word on pop, otherwise shift out one byte per take.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            rem   <= '0;
        end else if (take) begin
            if (holding) begin
                shreg <= shreg >> 8;
                rem   <= rem - LANE_W'(1);
            end else begin
                shreg <= head >> 8;
                rem   <= LANE_W'(LANES - 1);
            end
        end
    end
endmodule

// File: rtl/card_data_mover.sv
// Data engine between a word FIFO and a byte-wide card. Holds the length register, the
// byte counter, the enable and direction state, and the status map. Moves one byte per cycle at most.
// Assumes len_wr and ctl_wr are not asserted together.
module card_data_mover #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LEN_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic                       ctl_en,
    input  logic                       ctl_dir,
    input  logic                       len_wr,
    input  logic [LEN_W-1:0]           len_data,
    input  logic                       push_vld,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop_req,
    output logic [WIDTH-1:0]           pop_data,
    input  logic                       card_rdy,
    input  logic [7:0]                 card_rd_data,
    output logic                       card_rd,
    output logic                       card_wr,
    output logic [7:0]                 card_wr_data,
    output logic                       busy,
    output logic [LEN_W-1:0]           bytes_left,
    output logic [engine_pkg::STAT_W-1:0] stat,
    output logic                       fifo_err
);
    import engine_pkg::*;

    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int HALF  = DEPTH / 2;

    logic             en_q;
    xfer_dir_e        dir_q;
    logic             done_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    logic             f_wr, f_rd, f_full, f_empty;
    logic [WIDTH-1:0] f_wdata, f_head;
    logic [CNT_W-1:0] f_count;

    logic             pk_push;
    logic [WIDTH-1:0] pk_word;
    logic             up_pop, up_holding;
    logic [7:0]       up_byte;

    logic             cnt_nz, rd_go, wr_go, arm;

    assign cnt_nz = (cnt_q != '0);
    assign arm    = ctl_wr && ctl_en;
    assign rd_go  = en_q && (dir_q == DIR_FROM_CARD) && cnt_nz && card_rdy && !f_full;
    assign wr_go  = en_q && (dir_q == DIR_TO_CARD) && cnt_nz && (up_holding || !f_empty);

    // FIFO port ownership follows the direction.
    assign f_wr    = (dir_q == DIR_FROM_CARD) ? pk_push : push_vld;
    assign f_wdata = (dir_q == DIR_FROM_CARD) ? pk_word : push_data;
    assign f_rd    = (dir_q == DIR_FROM_CARD) ? pop_req : up_pop;

    mover_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(f_wr), .wr_data(f_wdata), .rd_en(f_rd),
        .head(f_head), .count(f_count), .full(f_full), .empty(f_empty), .err(fifo_err)
    );

    mover_byte_packer #(.WIDTH(WIDTH)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(arm), .take(rd_go), .last(cnt_q == LEN_W'(1)),
        .byte_in(card_rd_data), .push(pk_push), .word_out(pk_word)
    );

    mover_byte_unpacker #(.WIDTH(WIDTH)) u_unpack (
        .clk(clk), .rst_n(rst_n), .clear(arm), .take(wr_go), .head(f_head),
        .byte_out(up_byte), .need_pop(up_pop), .holding(up_holding)
    );

    assign card_rd      = rd_go;
    assign card_wr      = wr_go;
    assign card_wr_data = up_byte;
    assign pop_data     = f_head;
    assign busy         = en_q;
    assign bytes_left   = cnt_q;

    // Length register capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_wr) begin
            len_q <= len_data;
        end
    end

    // Enable, direction and byte counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dir_q <= DIR_TO_CARD;
            cnt_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= ctl_en;
            dir_q <= xfer_dir_e'(ctl_dir);
            if (ctl_en) begin
                cnt_q <= len_q;
            end
        end else begin
            if (rd_go || wr_go) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
            if (en_q && !cnt_nz && f_empty) begin
                en_q <= 1'b0;
            end
        end
    end

    // Data-end latch: set once an enabled count is exhausted, cleared on re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            done_q <= 1'b0;
        end else if (en_q && !cnt_nz) begin
            done_q <= 1'b1;
        end
    end

    // Status map: completion bits plus direction-gated FIFO level flags.
    always_comb begin
        stat = '0;
        stat[BIT_DATA_END]  = done_q;
        stat[BIT_BLOCK_END] = done_q;
        if (en_q) begin
            if (dir_q == DIR_FROM_CARD) begin
                stat[BIT_RX_ACTIVE]   = 1'b1;
                stat[BIT_RX_HALF_FUL] = (f_count >= CNT_W'(HALF));
                stat[BIT_RX_FULL]     = f_full;
                stat[BIT_RX_EMPTY]    = f_empty;
                stat[BIT_RX_AVAIL]    = !f_empty;
            end else begin
                stat[BIT_TX_ACTIVE]   = 1'b1;
                stat[BIT_TX_HALF_EMP] = (f_count <= CNT_W'(HALF));
                stat[BIT_TX_FULL]     = f_full;
                stat[BIT_TX_EMPTY]    = f_empty;
                stat[BIT_TX_AVAIL]    = !f_empty;
            end
        end
    end

    AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_en && !len_wr) |=> (busy && bytes_left == $past(len_q))); // R2
    AST_ONE_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (card_rd || card_wr) && !ctl_wr) |=> (bytes_left == $past(bytes_left) - LEN_W'(1))); // R4
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({card_rd, card_wr})); // R4
    AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bytes_left == '0 && !ctl_wr) |=> (stat[BIT_DATA_END] && stat[BIT_BLOCK_END])); // R7
    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bytes_left == '0 && f_empty && !ctl_wr) |=> !busy); // R8
endmodule

// File: tb/sim_card_data_mover.sv
module sim_card_data_mover;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_en = 1'b0, ctl_dir = 1'b0;
    logic        len_wr = 1'b0;
    logic [15:0] len_data = '0;
    logic        push_vld = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic [31:0] pop_data;
    logic        card_rdy = 1'b0;
    logic [7:0]  card_rd_data = '0;
    logic        card_rd, card_wr;
    logic [7:0]  card_wr_data;
    logic        busy;
    logic [15:0] bytes_left;
    logic [21:0] stat;
    logic        fifo_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    int idx = 0, took = 0, seed = 0, rdy_mode = 0, cyc = 0, ncap = 0;
    logic [7:0] capt [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    card_data_mover u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dir(ctl_dir),
        .len_wr(len_wr), .len_data(len_data), .push_vld(push_vld), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .card_rdy(card_rdy), .card_rd_data(card_rd_data),
        .card_rd(card_rd), .card_wr(card_wr), .card_wr_data(card_wr_data), .busy(busy),
        .bytes_left(bytes_left), .stat(stat), .fifo_err(fifo_err)
    );

    function automatic logic [7:0] fbyte(input int s, input int k);
        return 8'((k * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] word_of(input int s, input int w, input int len);
        logic [31:0] v = '0;
        for (int j = 0; j < 4; j++) begin
            if (4 * w + j < len) v[8*j +: 8] = fbyte(s, 4 * w + j);
        end
        return v;
    endfunction

    // Receive-side flags relative to bit 12, for a FIFO holding c words.
    function automatic logic [9:0] rx_flags(input int c);
        logic [9:0] v = '0;
        v[1] = 1'b1;
        v[3] = (c >= 8);
        v[5] = (c == 16);
        v[7] = (c == 0);
        v[9] = (c > 0);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Card model and byte capture, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        idx = idx + took;
        took = 0;
        card_rd_data = fbyte(seed, idx);
        card_rdy = (rdy_mode == 0) || (rdy_mode == 1 && cyc[0]);
        #1;
        if (card_rd) took = 1;
        if (card_wr) begin
            capt[ncap[7:0]] = card_wr_data;
            ncap++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_len(input int len);
        @(negedge clk); len_wr = 1'b1; len_data = 16'(len);
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic ctl(input logic en, input logic dir);
        @(negedge clk); ctl_wr = 1'b1; ctl_en = en; ctl_dir = dir;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        push_vld = 1'b1; push_data = w;
        @(negedge clk); push_vld = 1'b0;
    endtask

    task automatic pop_word();
        pop_req = 1'b1;
        @(negedge clk); pop_req = 1'b0;
    endtask

    task automatic rd_test(input int len, input int mode, input int sd, input bit stall);
        int nw = (len + 3) / 4;
        @(negedge clk);
        seed = sd; idx = 0; took = 0;
        rdy_mode = stall ? 2 : mode;
        set_len(len);
        ctl(1'b1, 1'b1);
        check("R2 counter load", 32'(bytes_left), 32'(len));
        check("R2 busy on arm", 32'(busy), 32'd1);
        check("R7 end bit cleared on arm", 32'(stat[8]), 32'd0);
        if (stall) begin
            repeat (10) @(negedge clk);
            check("R4 no byte without ready", 32'(bytes_left), 32'(len));
            rdy_mode = mode;
        end
        repeat (2 * len + 20) @(negedge clk);
        if (len > 64) begin
            check("R4 stop on full FIFO", 32'(bytes_left), 32'(len - 64));
            check("R9 rx full flag", 32'(stat[17]), 32'd1);
        end else begin
            check("R7 data end and block end", 32'({stat[10], stat[8]}), 32'd3);
        end
        for (int w = 0; w < nw; w++) begin
            for (int t = 0; t < 50 && !stat[21]; t++) @(negedge clk);
            if (bytes_left == 0)
                check("R9 rx flags", 32'(stat[21:12]), 32'(rx_flags(nw - w)));
            check((4 * w + 4 > len) ? "R5 partial word" : "R3 packed word",
                  pop_data, word_of(sd, w, len));
            pop_word();
        end
        repeat (3) @(negedge clk);
        check("R8 busy released", 32'(busy), 32'd0);
        check("R10 idle flags", 32'(stat[21:12]), 32'd0);
    endtask

    task automatic wr_test(input int len, input int sd);
        int nw = (len + 3) / 4;
        @(negedge clk);
        ncap = 0;
        set_len(len);
        ctl(1'b1, 1'b0);
        check("R9 tx flags when empty", 32'(stat[21:12]), 32'b0001000101);
        for (int w = 0; w < nw; w++) begin
            push_word({fbyte(sd, 4*w+3), fbyte(sd, 4*w+2), fbyte(sd, 4*w+1), fbyte(sd, 4*w)});
        end
        repeat (4 * nw + 10) @(negedge clk);
        check("R6 byte count sent", 32'(ncap), 32'(len));
        for (int k = 0; k < len && k < ncap; k++) begin
            check("R6 byte order", 32'(capt[k]), 32'(fbyte(sd, k)));
        end
        check("R7 data end", 32'(stat[8]), 32'd1);
        check("R8 busy released", 32'(busy), 32'd0);
    endtask

    initial begin
        int rl[19] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 12, 13, 16, 29, 32, 33, 63, 64, 70};
        int wl[11] = '{1, 2, 3, 4, 5, 7, 8, 9, 16, 17, 40};
        do_reset();
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 count", 32'(bytes_left), 32'd0);
        check("R1 status", 32'(stat), 32'd0);
        check("R1 error", 32'(fifo_err), 32'd0);
        check("R1 strobes", 32'({card_rd, card_wr}), 32'd0);

        for (int i = 0; i < 19; i++) rd_test(rl[i], i % 2, i + 1, 1'b0);
        rd_test(8, 0, 40, 1'b1);
        for (int i = 0; i < 11; i++) wr_test(wl[i], 50 + i);
        check("R11 no error in normal use", 32'(fifo_err), 32'd0);

        // R11 overflow: 17th push dropped, FIFO still holds 16 words in order
        do_reset();
        ctl(1'b0, 1'b0);
        for (int w = 0; w < 16; w++) push_word(32'hA000_0000 + 32'(w));
        check("R11 no error at exactly full", 32'(fifo_err), 32'd0);
        push_word(32'hDEAD_BEEF);
        check("R11 overflow flagged", 32'(fifo_err), 32'd1);
        set_len(0);
        ctl(1'b1, 1'b1);
        check("R9 rx flags at full", 32'(stat[21:12]), 32'(rx_flags(16)));
        for (int w = 0; w < 16; w++) begin
            check("R11 contents kept", pop_data, 32'hA000_0000 + 32'(w));
            pop_word();
        end
        repeat (2) @(negedge clk);
        check("R8 busy after drain", 32'(busy), 32'd0);

        // R11 underflow
        do_reset();
        ctl(1'b0, 1'b1);
        @(negedge clk);
        pop_word();
        check("R11 underflow flagged", 32'(fifo_err), 32'd1);

        // R2 register push ignored in card-to-host direction
        do_reset();
        ctl(1'b0, 1'b1);
        push_word(32'h1234_5678);
        set_len(0);
        ctl(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R2 push ignored in read direction", 32'(busy), 32'd0);
        check("R2 ignored push raises no error", 32'(fifo_err), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule